// File: doc/BRIEF.md
# Center-Aligned Timer Counter with Update Control

This block is the counting core of a motor-control PWM timer. A counter of parameterised width (16 bits by default) moves one step on each cycle in which the prescaler enable is high. It either runs as a sawtooth in edge-aligned mode, counting up or down as a direction input selects, or as a triangle in one of three center-aligned modes. The three center-aligned modes differ only in which count direction may raise the compare flag. Each turnaround produces an overflow or underflow. It becomes an update event unless update events are disabled. The update event also copies the software-written reload and compare values into the active copies that the counter uses.

A software update strobe and a slave-mode restart strobe reinitialise the counter. They also pulse an output that clears the external prescaler's phase. These strobes are update sources in their own right. A restriction bit can keep them from raising the update interrupt, so that only overflow or underflow does. A free-running divider turns the timer clock into an enable for the dead-time and filter sampling clock.

Top module: `pwm_sweep_timer`

## Requirements
- R1: With mode 00 and the direction input low, each enabled step increments the count. A step taken at or above the active reload value wraps the count to 0 and produces an update event.
- R2: With mode 00 and the direction input high, each enabled step decrements the count. A step taken at 0 loads the active reload value and produces an update event.
- R3: In modes 01, 10 and 11 the count climbs from 0 to the active reload value, turns and falls back to 0, then climbs again. An update event is produced at both turnarounds. The direction output is high while the count falls.
- R4: The compare flag pulses for one cycle after a step whose new count equals the active compare value. Mode 00 and mode 11 allow such steps in either direction. Mode 01 allows only falling steps. Mode 10 allows only rising steps.
- R5: The sampling enable is high on every cycle for division code 00, on one cycle in 2 for code 01, and on one cycle in 4 for code 10. The reserved code 11 behaves as code 00.
- R6: When the interrupt restriction bit is 1, the software strobe and the slave restart still produce an update event, but no update interrupt. Overflow and underflow still raise the interrupt.
- R7: When the update-disable bit is 1, no update event and no update interrupt is produced, and the active reload and compare values do not change. The software strobe and the slave restart still reinitialise the counter.
- R8: An update event copies the reload and compare inputs into the active values. The new reload value governs counting from the next step on.
- R9: Reinitialisation sets the count to 0 and the direction to rising. In mode 00 with the direction input high, it sets the count to the reload value that is active after that cycle instead. Each strobe causes a one-cycle prescaler-clear pulse.
- R10: The count holds when the step enable is low and no strobe is present.
- R11: The update interrupt is never high without the update event pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Step enable from the prescaler |
| cntMode | input | 2 | 00 edge-aligned, 01/10/11 center-aligned variants |
| downDir | input | 1 | Edge-aligned direction, 1 counts down |
| clkDivSel | input | 2 | Sampling clock division code |
| updEvtOff | input | 1 | 1 suppresses update events |
| updIrqRestrict | input | 1 | 1 limits the interrupt to overflow/underflow |
| swUpdate | input | 1 | Software update strobe |
| slaveRestart | input | 1 | Slave-mode restart strobe |
| reloadIn | input | CNT_W | Reload value as written by software |
| compareIn | input | CNT_W | Compare value as written by software |
| count | output | CNT_W | Current count |
| countingDown | output | 1 | Current count direction |
| cmpFlag | output | 1 | Compare match pulse |
| updEvent | output | 1 | Update event pulse |
| updIrq | output | 1 | Update interrupt pulse |
| prescClr | output | 1 | Prescaler phase clear pulse |
| sampleEn | output | 1 | Sampling clock enable |

## Verification
On every cycle the assertions check several properties. The interrupt never appears without its event. The disable bit always silences the event, and the restriction bit silences the interrupt whenever no step can wrap. The count freezes without a step or strobe, and every strobe produces the prescaler clear. The two single-direction center modes only flag compare in their own direction, and the divide-by-2 enable alternates. Only the bench scenarios can show the actual count sequences in edge and center modes and the turnaround positions. They also show that the shadow values are withheld and then transferred, the reload-valued reinitialisation in down-counting, and the enable density for each division code.

// File: rtl/pwm_sweep_pkg.sv
package pwm_sweep_pkg;

  typedef enum logic [1:0] {
    MODE_EDGE     = 2'b00,
    MODE_CTR_DOWN = 2'b01,
    MODE_CTR_UP   = 2'b10,
    MODE_CTR_BOTH = 2'b11
  } cntMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic reinit;      // restart count and direction
    logic loadActive;  // copy shadow reload/compare into active
    logic stepEn;      // take one counting step
  } dpCtrl_t;

endpackage

// File: rtl/pwm_sweep_div.sv
module pwm_sweep_div #(
  parameter int PHASE_W = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] clkDivSel,
  output logic       sampleEn
);
  logic [PHASE_W-1:0] phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else       phase <= phase + PHASE_W'(1);
  end

  always_comb begin
    unique case (clkDivSel)
      2'b01:   sampleEn = phase[0];
      2'b10:   sampleEn = &phase[1:0];
      default: sampleEn = 1'b1;  // 00 and reserved 11
    endcase
  end
endmodule

// File: rtl/pwm_sweep_dp.sv
module pwm_sweep_dp
  import pwm_sweep_pkg::*;
#(
  parameter int               CNT_W      = 16,
  parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntMode_e         mode,
  input  logic             downDir,
  input  logic [CNT_W-1:0] reloadIn,
  input  logic [CNT_W-1:0] compareIn,
  input  dpCtrl_t          ctrl,
  output logic             atTurn,
  output logic [CNT_W-1:0] count,
  output logic             countingDown,
  output logic             cmpFlag
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt, actReload, actCompare, nextCnt, reloadEff, reinitCnt;
  logic             dirDown, nextDir, stepIsDown, dirGate, cmpHit;
  logic             isEdge;

  assign isEdge = (mode == MODE_EDGE);

  always_comb begin
    nextCnt    = cnt;
    nextDir    = dirDown;
    atTurn     = 1'b0;
    stepIsDown = isEdge ? downDir : dirDown;
    if (isEdge) begin
      nextDir = 1'b0;
      if (!downDir) begin
        if (cnt >= actReload) begin
          nextCnt = '0;
          atTurn  = 1'b1;
        end else nextCnt = cnt + ONE;
      end else begin
        if (cnt == '0) begin
          nextCnt = actReload;
          atTurn  = 1'b1;
        end else nextCnt = cnt - ONE;
      end
    end else if (!dirDown) begin
      if (cnt >= actReload) begin
        atTurn     = 1'b1;
        nextDir    = 1'b1;
        stepIsDown = 1'b1;
        nextCnt    = (actReload == '0) ? '0 : actReload - ONE;
      end else nextCnt = cnt + ONE;
    end else begin
      if (cnt == '0) begin
        atTurn     = 1'b1;
        nextDir    = 1'b0;
        stepIsDown = 1'b0;
        nextCnt    = (actReload == '0) ? '0 : ONE;
      end else nextCnt = cnt - ONE;
    end
  end

  always_comb begin
    unique case (mode)
      MODE_CTR_DOWN: dirGate = stepIsDown;
      MODE_CTR_UP:   dirGate = !stepIsDown;
      default:       dirGate = 1'b1;
    endcase
    cmpHit    = dirGate && (nextCnt == actCompare);
    reloadEff = ctrl.loadActive ? reloadIn : actReload;
    reinitCnt = (isEdge && downDir) ? reloadEff : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      dirDown <= 1'b0;
      cmpFlag <= 1'b0;
    end else if (ctrl.reinit) begin
      cnt     <= reinitCnt;
      dirDown <= 1'b0;
      cmpFlag <= 1'b0;
    end else if (ctrl.stepEn) begin
      cnt     <= nextCnt;
      dirDown <= nextDir;
      cmpFlag <= cmpHit;
    end else begin
      cmpFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actReload  <= RELOAD_RST;
      actCompare <= '0;
    end else if (ctrl.loadActive) begin
      actReload  <= reloadIn;
      actCompare <= compareIn;
    end
  end

  assign count        = cnt;
  assign countingDown = isEdge ? downDir : dirDown;
endmodule

// File: rtl/pwm_sweep_ctrl.sv
module pwm_sweep_ctrl
  import pwm_sweep_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tickEn,
  input  logic    updEvtOff,
  input  logic    updIrqRestrict,
  input  logic    swUpdate,
  input  logic    slaveRestart,
  input  logic    atTurn,
  output dpCtrl_t ctrl,
  output logic    updEvent,
  output logic    updIrq,
  output logic    prescClr
);
  logic reinit, wrapNow, evtFire, irqFire;

  always_comb begin
    reinit          = swUpdate || slaveRestart;
    ctrl.reinit     = reinit;
    ctrl.stepEn     = tickEn && !reinit;
    wrapNow         = ctrl.stepEn && atTurn;
    evtFire         = !updEvtOff && (wrapNow || reinit);
    irqFire         = evtFire && (wrapNow || !updIrqRestrict);
    ctrl.loadActive = evtFire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updEvent <= 1'b0;
      updIrq   <= 1'b0;
      prescClr <= 1'b0;
    end else begin
      updEvent <= evtFire;
      updIrq   <= irqFire;
      prescClr <= reinit;
    end
  end
endmodule

// File: rtl/pwm_sweep_timer.sv
module pwm_sweep_timer
  import pwm_sweep_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PHASE_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic [1:0]       cntMode,
  input  logic             downDir,
  input  logic [1:0]       clkDivSel,
  input  logic             updEvtOff,
  input  logic             updIrqRestrict,
  input  logic             swUpdate,
  input  logic             slaveRestart,
  input  logic [CNT_W-1:0] reloadIn,
  input  logic [CNT_W-1:0] compareIn,
  output logic [CNT_W-1:0] count,
  output logic             countingDown,
  output logic             cmpFlag,
  output logic             updEvent,
  output logic             updIrq,
  output logic             prescClr,
  output logic             sampleEn
);
  dpCtrl_t dpCtrl;
  logic    atTurn;

  pwm_sweep_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .updEvtOff(updEvtOff),
    .updIrqRestrict(updIrqRestrict), .swUpdate(swUpdate),
    .slaveRestart(slaveRestart), .atTurn(atTurn), .ctrl(dpCtrl),
    .updEvent(updEvent), .updIrq(updIrq), .prescClr(prescClr)
  );

  pwm_sweep_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .mode(cntMode_e'(cntMode)), .downDir(downDir),
    .reloadIn(reloadIn), .compareIn(compareIn), .ctrl(dpCtrl),
    .atTurn(atTurn), .count(count), .countingDown(countingDown),
    .cmpFlag(cmpFlag)
  );

  pwm_sweep_div #(.PHASE_W(PHASE_W)) uDiv (
    .clk(clk), .rstN(rstN), .clkDivSel(clkDivSel), .sampleEn(sampleEn)
  );
endmodule

// File: rtl/pwm_sweep_chk.sv
module pwm_sweep_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic [1:0]       cntMode,
  input logic [1:0]       clkDivSel,
  input logic             updEvtOff,
  input logic             updIrqRestrict,
  input logic             swUpdate,
  input logic             slaveRestart,
  input logic [CNT_W-1:0] count,
  input logic             countingDown,
  input logic             cmpFlag,
  input logic             updEvent,
  input logic             updIrq,
  input logic             prescClr,
  input logic             sampleEn
);
  a_r11_irq_needs_event: assert property (@(posedge clk) disable iff (!rstN)
    updIrq |-> updEvent);

  a_r7_event_suppressed: assert property (@(posedge clk) disable iff (!rstN)
    updEvtOff |=> !updEvent);

  a_r6_strobe_no_irq: assert property (@(posedge clk) disable iff (!rstN)
    (updIrqRestrict && !tickEn) |=> !updIrq);

  a_r10_count_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !swUpdate && !slaveRestart) |=> $stable(count));

  a_r9_presc_clear: assert property (@(posedge clk) disable iff (!rstN)
    (swUpdate || slaveRestart) |=> prescClr);

  a_r4_rise_only: assert property (@(posedge clk) disable iff (!rstN)
    (cntMode == 2'b10 && $stable(cntMode) && cmpFlag) |-> !countingDown);

  a_r4_fall_only: assert property (@(posedge clk) disable iff (!rstN)
    (cntMode == 2'b01 && $stable(cntMode) && cmpFlag) |-> countingDown);

  a_r5_half_rate: assert property (@(posedge clk) disable iff (!rstN)
    (clkDivSel == 2'b01 && $stable(clkDivSel) && sampleEn) |=>
      (clkDivSel != 2'b01 || !sampleEn));
endmodule

bind pwm_sweep_timer pwm_sweep_chk #(.CNT_W(CNT_W)) uChk (.*);

// File: tb/tb_pwm_sweep_timer.sv
`timescale 1ns/1ps
module tb_pwm_sweep_timer;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 0, downDir = 0, updEvtOff = 0, updIrqRestrict = 0;
  logic swUpdate = 0, slaveRestart = 0;
  logic [1:0] cntMode = 2'b00, clkDivSel = 2'b00;
  logic [W-1:0] reloadIn = '0, compareIn = '0;
  logic [W-1:0] count;
  logic countingDown, cmpFlag, updEvent, updIrq, prescClr, sampleEn;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_sweep_timer #(.CNT_W(W)) dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cntMode(cntMode),
    .downDir(downDir), .clkDivSel(clkDivSel), .updEvtOff(updEvtOff),
    .updIrqRestrict(updIrqRestrict), .swUpdate(swUpdate),
    .slaveRestart(slaveRestart), .reloadIn(reloadIn), .compareIn(compareIn),
    .count(count), .countingDown(countingDown), .cmpFlag(cmpFlag),
    .updEvent(updEvent), .updIrq(updIrq), .prescClr(prescClr),
    .sampleEn(sampleEn)
  );

  // Center sweep, reload 3, compare 2, mode 11: {count, down, event, cmp}
  localparam logic [W+2:0] SWEEP [9] = '{
    {16'd0, 1'b0, 1'b1, 1'b0},
    {16'd1, 1'b0, 1'b0, 1'b0},
    {16'd2, 1'b0, 1'b0, 1'b1},
    {16'd3, 1'b0, 1'b0, 1'b0},
    {16'd2, 1'b1, 1'b1, 1'b1},
    {16'd1, 1'b1, 1'b0, 1'b0},
    {16'd0, 1'b1, 1'b0, 1'b0},
    {16'd1, 1'b0, 1'b1, 1'b0},
    {16'd2, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulseSw();
    swUpdate = 1'b1;
    @(negedge clk);
    swUpdate = 1'b0;
  endtask

  task automatic pulseSlave();
    slaveRestart = 1'b1;
    @(negedge clk);
    slaveRestart = 1'b0;
  endtask

  task automatic ticks(input int n);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic modeFlags(input logic [1:0] m, input int expFlags,
                           input int expDownFlags, input string req);
    int flags = 0, downFlags = 0;
    cntMode = m; reloadIn = 16'd3; compareIn = 16'd2;
    pulseSw();
    tickEn = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (cmpFlag) begin
        flags++;
        if (countingDown) downFlags++;
      end
    end
    tickEn = 1'b0;
    chk({req, " flag count"}, flags, expFlags);
    chk({req, " flags while falling"}, downFlags, expDownFlags);
  endtask

  task automatic divCount(input logic [1:0] sel, input int exp);
    int hi = 0;
    clkDivSel = sel;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (sampleEn) hi++;
    end
    chk("R5 sampling enable density", hi, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state
    chk("R10 reset count", int'(count), 0);
    chk("R11 reset event/irq", int'({updEvent, updIrq}), 0);
    chk("R4 reset cmp", int'(cmpFlag), 0);

    // R3 center sweep walked from the table
    cntMode = 2'b11; reloadIn = 16'd3; compareIn = 16'd2;
    pulseSw();
    chk("R3 sweep start", int'(SWEEP[0]), int'({count, countingDown, updEvent, cmpFlag}));
    tickEn = 1'b1;
    for (int i = 1; i < 9; i++) begin
      @(negedge clk);
      chk("R3 sweep step", int'({count, countingDown, updEvent, cmpFlag}), int'(SWEEP[i]));
    end
    tickEn = 1'b0;

    // R1 edge up wrap
    cntMode = 2'b00; downDir = 1'b0; reloadIn = 16'd2; compareIn = 16'd9;
    pulseSw();
    ticks(3);
    chk("R1 wrap count/event/irq", int'({count, updEvent, updIrq}), int'({16'd0, 1'b1, 1'b1}));

    // R2 edge down reload
    downDir = 1'b1;
    pulseSw();
    chk("R9 down reinit to new reload", int'(count), 2);
    ticks(3);
    chk("R2 underflow count/event", int'({count, updEvent}), int'({16'd2, 1'b1}));
    downDir = 1'b0;

    // R4 direction gating of compare
    modeFlags(2'b00, 2, 0, "R4 mode00");
    modeFlags(2'b01, 1, 1, "R4 mode01");
    modeFlags(2'b10, 1, 0, "R4 mode10");
    modeFlags(2'b11, 2, 1, "R4 mode11");

    // R6 restricted interrupt sources
    cntMode = 2'b00; updIrqRestrict = 1'b1; reloadIn = 16'd1; compareIn = 16'd0;
    pulseSw();
    chk("R6 strobe event without irq", int'({updEvent, updIrq}), int'(2'b10));
    ticks(2);
    chk("R6 overflow still raises irq", int'({count, updEvent, updIrq}), int'({16'd0, 1'b1, 1'b1}));
    updIrqRestrict = 1'b0;

    // R7 update events disabled
    updEvtOff = 1'b1; reloadIn = 16'd5;
    pulseSw();
    chk("R7 reinit without event", int'({count, updEvent, updIrq, prescClr}), int'({16'd0, 1'b0, 1'b0, 1'b1}));
    ticks(2);
    chk("R7 old reload kept", int'({count, updEvent}), int'({16'd0, 1'b0}));
    ticks(1);
    pulseSlave();
    chk("R7 slave restart reinit", int'({count, updEvent, prescClr}), int'({16'd0, 1'b0, 1'b1}));

    // R8 transfer on event
    updEvtOff = 1'b0;
    pulseSlave();
    chk("R8 slave update event", int'(updEvent), 1);
    ticks(2);
    chk("R8 new reload in force", int'(count), 2);

    // R9 down reinit uses active reload when event is off
    updEvtOff = 1'b1; reloadIn = 16'd7; downDir = 1'b1;
    pulseSw();
    chk("R9 down reinit to active reload", int'({count, prescClr}), int'({16'd5, 1'b1}));

    // R10 hold without step enable
    repeat (3) @(negedge clk);
    chk("R10 count held", int'(count), 5);
    downDir = 1'b0; updEvtOff = 1'b0;

    // R5 sampling enable
    divCount(2'b00, 8);
    divCount(2'b01, 4);
    divCount(2'b10, 2);
    divCount(2'b11, 8);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule